// File: doc/BRIEF.md
# Integer to Float Normalizer

This block turns a signed two's-complement integer into a packed floating point word laid out for byte-wide handling. The top byte is the exponent, stored with a bias of 127. The bit just below that byte carries the sign, in the slot that the implicit leading one of the mantissa would otherwise fill. The low 23 bits hold the fraction that lies below that implicit one. The exponent field has no reserved codes. An input of zero gives the all-zero word, and that word is the only encoding of zero.

A one-cycle `start` while the block is idle captures `din`. The block splits the input into a sign and a magnitude. It then moves the magnitude left by one place per clock until the top bit is set, and lowers the exponent by one for each move. The eight bits that fall below the fraction form a guard byte. The fraction is rounded to nearest from that byte, with a tie going to the even value. `done` pulses once when `dout` holds the new result, and `dout` keeps that result until the next one. While `busy` is high, further start pulses are dropped.

Top module: `i2f_normalizer`

## Requirements
- R1: An input of 0 produces `dout` = 32'h0000_0000.
- R2: For a nonzero input, `dout[31:24]` equals 127 plus the bit index of the most significant one in |din|, plus one when rounding carries. The result lies in the range 127 to 158.
- R3: `dout[23]` is 1 for a negative input and 0 for a zero or positive input.
- R4: `dout[22:0]` holds the 23 bits of |din| just below its leading one, zero-filled on the right. When the 8 bits below those (the guard byte) are under 8'h80, the fraction is truncated.
- R5: When the guard byte is above 8'h80, the fraction is incremented. When the guard byte equals exactly 8'h80, the fraction is incremented only if its bit 0 is 1. Bits below the guard byte have no effect.
- R6: When the increment overflows the 23-bit fraction, the fraction becomes 0 and the exponent rises by one. For example, 32'h7FFF_FFFF gives 32'h9E00_0000.
- R7: The input 32'h8000_0000 (-2^31) gives 32'h9E80_0000.
- R8: After reset, `busy`, `done` and `dout` are 0. A `start` taken while idle makes `busy` high from the next cycle. `done` lasts exactly one cycle, and `busy` is low in that cycle.
- R9: A `start` that arrives while `busy` is high is ignored. It does not change the pending result and produces no extra `done`.
- R10: Let L be the number of leading zeros of the 32-bit |din| (L = 0 for zero). `done` rises on the (L+2)-th rising edge after the edge that samples `start`.
- R11: `dout` changes only in a cycle where `done` is high, and it holds its value between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to convert `din`; acted on only when idle |
| din | input | 32 | Signed two's-complement integer |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when `dout` holds a new result |
| dout | output | 32 | Packed word: exponent [31:24], sign [23], fraction [22:0] |

## Verification
The protocol assertions assume that `start` is a one-cycle pulse driven away from the clock edge. They also assume that `din` is stable in the cycle in which `start` is sampled. The bench drives both signals only on falling edges and releases `start` after one cycle. The bench sends start pulses during `busy` on purpose, to show that these pulses are dropped. The exponent-range and zero-encoding checks need no assumption about `din`, because every 32-bit pattern is a legal integer. The stimulus covers directed values around each rounding boundary, the most negative input and a pseudo-random sweep.

// File: rtl/i2f_pkg.sv
// Shared types for the integer to float normalizer.
package i2f_pkg;
    // Control phases: waiting, aligning the leading one, rounding and packing.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_ROUND = 2'd2
    } i2f_state_e;
endpackage

// File: rtl/i2f_sign_mag.sv
// Splits a two's-complement integer into sign, unsigned magnitude and a zero flag.
// Assumes IN_W >= 2. The most negative value maps to magnitude 2^(IN_W-1), which fits
// in IN_W unsigned bits.
module i2f_sign_mag #(
    parameter int IN_W = 32
) (
    input  logic [IN_W-1:0] din,
    output logic            neg,
    output logic [IN_W-1:0] mag,
    output logic            is_zero
);
    localparam logic [IN_W-1:0] ONE = {{(IN_W-1){1'b0}}, 1'b1};

    // Negate negative inputs; zero is flagged so that no alignment is attempted.
    always_comb begin
        neg     = din[IN_W-1];
        mag     = neg ? (~din + ONE) : din;
        is_zero = (din == '0);
    end
endmodule

// File: rtl/i2f_norm_shift.sv
// Holds the magnitude and its running exponent. On load it sets the exponent for a
// leading one at bit W-1. On step it moves the magnitude left by one place and
// decrements the exponent, until the top bit is set. Assumes BIAS+W-1 fits in EXP_W bits.
module i2f_norm_shift #(
    parameter int W     = 32,
    parameter int EXP_W = 8,
    parameter int BIAS  = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [W-1:0]     mag_in,
    input  logic             step,
    output logic [W-1:0]     mag_q,
    output logic [EXP_W-1:0] exp_q,
    output logic             lead
);
    localparam logic [EXP_W-1:0] EXP_TOP = EXP_W'(BIAS + W - 1);
    localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(1);

    // Load, or take one alignment step while the top bit is still clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_q <= '0;
            exp_q <= '0;
        end else if (load) begin
            mag_q <= mag_in;
            exp_q <= EXP_TOP;
        end else if (step && !mag_q[W-1]) begin
            mag_q <= {mag_q[W-2:0], 1'b0};
            exp_q <= exp_q - EXP_ONE;
        end
    end

    assign lead = mag_q[W-1];
endmodule

// File: rtl/i2f_round_pack.sv
// Rounds an aligned magnitude to nearest, with ties to even, and packs the word
// {exponent, sign, fraction}. The bit at W-1 is the implicit one. The next FRAC_W bits
// form the fraction and the next GUARD_W bits decide rounding. Any lower bits are
// dropped. Assumes W-1-FRAC_W >= GUARD_W >= 1.
module i2f_round_pack #(
    parameter int W       = 32,
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int GUARD_W = 8
) (
    input  logic [W-1:0]              mag,
    input  logic [EXP_W-1:0]          exp_in,
    input  logic                      neg,
    input  logic                      is_zero,
    output logic [EXP_W+FRAC_W:0]     word
);
    localparam int                 LOW_W = W - 1 - FRAC_W;
    localparam logic [GUARD_W-1:0] HALF  = {1'b1, {(GUARD_W-1){1'b0}}};

    logic [FRAC_W-1:0]  frac;
    logic [GUARD_W-1:0] guard;
    logic               round_up;
    logic [FRAC_W:0]    sum;
    logic [EXP_W-1:0]   exp_out;

    // Nearest-even decision from the guard byte, then carry into the exponent.
    always_comb begin
        frac     = mag[W-2 -: FRAC_W];
        guard    = mag[LOW_W-1 -: GUARD_W];
        round_up = (guard > HALF) || ((guard == HALF) && frac[0]);
        sum      = {1'b0, frac} + {{FRAC_W{1'b0}}, round_up};
        exp_out  = exp_in + {{(EXP_W-1){1'b0}}, sum[FRAC_W]};
        word     = is_zero ? '0 : {exp_out, neg, sum[FRAC_W-1:0]};
    end
endmodule

// File: rtl/i2f_normalizer.sv
// Top level of the integer to float normalizer. A start pulse taken while idle
// captures din. The magnitude is aligned one place per clock, then rounded and packed.
// done pulses for one cycle with the new dout, and start pulses during busy are
// ignored. Assumes IN_W - 1 - FRAC_W >= GUARD_W.
module i2f_normalizer
    import i2f_pkg::*;
#(
    parameter int IN_W    = 32,
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int GUARD_W = 8,
    parameter int BIAS    = 127
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [IN_W-1:0]       din,
    output logic                  busy,
    output logic                  done,
    output logic [EXP_W+FRAC_W:0] dout
);
    localparam int OUT_W = EXP_W + FRAC_W + 1;

    i2f_state_e           state;
    logic                 neg_c, zero_c;
    logic [IN_W-1:0]      mag_c, mag_q;
    logic [EXP_W-1:0]     exp_q;
    logic                 lead;
    logic                 neg_q, zero_q;
    logic                 accept;
    logic [OUT_W-1:0]     packed_c;

    assign accept = start && (state == ST_IDLE);

    i2f_sign_mag #(.IN_W(IN_W)) u_sm (
        .din     (din),
        .neg     (neg_c),
        .mag     (mag_c),
        .is_zero (zero_c)
    );

    i2f_norm_shift #(.W(IN_W), .EXP_W(EXP_W), .BIAS(BIAS)) u_sh (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .mag_in (mag_c),
        .step   (state == ST_SHIFT),
        .mag_q  (mag_q),
        .exp_q  (exp_q),
        .lead   (lead)
    );

    i2f_round_pack #(.W(IN_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .GUARD_W(GUARD_W)) u_rp (
        .mag     (mag_q),
        .exp_in  (exp_q),
        .neg     (neg_q),
        .is_zero (zero_q),
        .word    (packed_c)
    );

    // Sequence the phases and register the sign, zero flag, result and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            neg_q  <= 1'b0;
            zero_q <= 1'b0;
            done   <= 1'b0;
            dout   <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    neg_q  <= neg_c;
                    zero_q <= zero_c;
                    state  <= ST_SHIFT;
                end
                ST_SHIFT: if (lead || zero_q) state <= ST_ROUND;
                ST_ROUND: begin
                    dout  <= packed_c;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/i2f_normalizer_chk.sv
// Protocol and encoding checks for i2f_normalizer, attached by bind.
module i2f_normalizer_chk #(
    parameter int IN_W    = 32,
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int BIAS    = 127
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic [IN_W-1:0]       din,
    input logic                  busy,
    input logic                  done,
    input logic [EXP_W+FRAC_W:0] dout
);
    localparam int OUT_W = EXP_W + FRAC_W + 1;
    localparam logic [EXP_W-1:0] EXP_LO = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] EXP_HI = EXP_W'(BIAS + IN_W - 1);

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                                          // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                     // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                     // R8
    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);                                               // R9
    AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(dout));                                            // R11
    AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dout != '0) |-> (dout[OUT_W-1 -: EXP_W] >= EXP_LO
                                  && dout[OUT_W-1 -: EXP_W] <= EXP_HI));     // R2
    AST_ZERO_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dout[OUT_W-1 -: EXP_W] == '0) |-> (dout == '0));            // R1
endmodule

bind i2f_normalizer i2f_normalizer_chk #(
    .IN_W(IN_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din),
    .busy(busy), .done(done), .dout(dout)
);

// File: tb/sim_i2f_normalizer.sv
// Scoreboard bench: the driver queues expected words and latencies, the monitor compares on done.
module sim_i2f_normalizer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] din = '0;
    logic        busy, done;
    logic [31:0] dout;

    typedef struct {
        logic [31:0] word;
        int          lz;
        int          t0;
        string       tag;
    } exp_item_t;

    exp_item_t   sb[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    int          cyc = 0;
    logic [31:0] last_word = '0;

    i2f_normalizer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .din(din),
        .busy(busy), .done(done), .dout(dout)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference built from the requirements: leading-one position, guard byte, ties to even.
    function automatic logic [31:0] ref_word(input logic [31:0] x, output int lz);
        logic [32:0] m;
        logic [31:0] al;
        logic [22:0] fr;
        logic [7:0]  g, e;
        logic [23:0] s;
        int          p;
        logic        up;
        m = x[31] ? (33'h1_0000_0000 - {1'b0, x}) : {1'b0, x};
        lz = 0;
        if (m == '0) return 32'h0;
        p = 0;
        for (int i = 0; i < 32; i++) if (m[i]) p = i;
        lz = 31 - p;
        al = m[31:0] << lz;
        fr = al[30:8];
        g  = al[7:0];
        up = (g > 8'h80) || (g == 8'h80 && fr[0]);
        s  = {1'b0, fr} + {23'b0, up};
        e  = 8'(127 + p) + {7'b0, s[23]};
        return {e, x[31], s[22:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Driver: wait for idle, pulse start, queue the expectation, confirm busy (R8).
    task automatic send(input logic [31:0] x, input string tag);
        exp_item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        din = x; start = 1'b1;
        it.word = ref_word(x, it.lz);
        it.t0 = cyc;
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        start = 1'b0;
        check("R8 busy after start", {31'b0, busy}, 32'd1);
    endtask

    // Send a value, then a second start during busy that must be dropped (R9).
    task automatic send_with_stray(input logic [31:0] x, input logic [31:0] y);
        send(x, "R9 stray start ignored");
        din = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: on each done, pop the oldest expectation and compare word and latency.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R9 unexpected done: actual %h expected none", dout);
            end else begin
                exp_item_t it;
                it = sb.pop_front();
                check(it.tag, dout, it.word);
                check("R10 latency", 32'(cyc - it.t0), 32'(it.lz + 3));
                last_word = it.word;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset busy", {31'b0, busy}, 32'd0);
        check("R8 reset done", {31'b0, done}, 32'd0);
        check("R11 reset dout", dout, 32'd0);

        send(32'h0000_0000, "R1 zero");
        send(32'h0000_0001, "R4 one");
        send(32'h0000_0005, "R4 five");
        send(32'h00FF_FFFF, "R4 exact 24 bits");
        send(32'hFFFF_FFFF, "R3 minus one");
        send(32'hFFFF_FFFB, "R3 minus five");
        send(32'h7FFF_FFFF, "R6 carry from all ones");
        check("R6 reference word", ref_word(32'h7FFF_FFFF, n_cmp), 32'h9E00_0000);
        send(32'h01FF_FFFF, "R6 tie with odd lsb carries");
        send(32'h8000_0000, "R7 most negative");
        check("R7 reference word", ref_word(32'h8000_0000, n_cmp), 32'h9E80_0000);
        send(32'h4000_0040, "R5 tie even stays");
        send(32'h4000_00C0, "R5 tie odd rounds up");
        send(32'h4000_0041, "R5 guard above half");
        send(32'h4000_003F, "R4 guard below half");
        send(32'hC000_0041, "R5 negative rounds up");
        send_with_stray(32'h0000_0003, 32'h1234_5678);
        send_with_stray(32'h8000_0000, 32'h0000_0001);
        for (int k = 0; k < 40; k++) begin
            logic [31:0] r;
            r = $urandom;
            r = r >> (k % 32);
            if (k % 3 == 0) r = -r;
            send(r, "R2 sweep");
        end
        @(negedge clk);
        while (busy || sb.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        check("R11 dout held", dout, last_word);
        check("R9 queue drained", 32'(sb.size()), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule